// File: doc/BRIEF.md
# Single-Accumulator Multicycle Processor Core

This block is a small multicycle processor built around one 16-bit accumulator and a 12-bit program counter. One word-addressed synchronous memory port carries both instruction fetches and data accesses. Every instruction fills exactly one 16-bit word: the upper four bits select the operation and the lower twelve bits give a direct memory address. The core can load, store, add, subtract, jump unconditionally, jump on the accumulator's sign or on a nonzero accumulator, and stop.

The memory port is a plain synchronous interface, not a stream. The core drives the address and write enable in one cycle, and the memory returns the read data on the next cycle. There is no back-pressure: the memory must accept one access every cycle. A build-time parameter sets whether the sign jump fires on "zero or positive" or only on "strictly positive". The `halted` output rises after a stop instruction and stays high until reset.

Top module: `acc_core`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `halted` and `mem_we` are 0 and `mem_addr` is 0. The accumulator starts at 0, and the first instruction is fetched from address 0.
- R2: A fetch drives `mem_addr` with the program counter, and the counter then advances by one. Address 4095 is followed by address 0.
- R3: Opcode 0x0 (instruction bits [15:12]) copies the word at the operand address (bits [11:0]) into the accumulator.
- R4: Opcode 0x1 drives the operand address, `mem_wdata` equal to the accumulator, and `mem_we` high, for exactly one cycle.
- R5: Opcode 0x2 adds the word at the operand address to the accumulator, and opcode 0x3 subtracts it. Both wrap silently modulo 2^16.
- R6: Opcode 0x4 always loads the program counter with the operand.
- R7: Opcode 0x5 jumps to the operand when the accumulator's bit 15 is 0. When `JUMP_STRICT` is 1, it also requires the accumulator to be nonzero.
- R8: Opcode 0x6 jumps to the operand when the accumulator is nonzero.
- R9: Opcode 0x7 stops the core, whatever its operand bits hold. `halted` goes high in the cycle after the stop is executed and stays high until reset, and `mem_we` stays 0 during that time.
- R10: Opcodes 0x8 to 0xF leave the accumulator and the memory unchanged, and execution continues at the next address.
- R11: Cycle timing: a fetch takes one cycle and is followed by an execute cycle. A load, add or subtract then uses one more cycle to consume the operand word before the next fetch. A store or a jump goes back to fetch straight after execute.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | Word address for the current memory access |
| mem_wdata | output | 16 | Store data (the accumulator) |
| mem_we | output | 1 | Write strobe for `mem_addr` |
| mem_rdata | input | 16 | Read data, valid one cycle after its address |
| halted | output | 1 | High once a stop instruction has executed |

## Verification
The bench covers the following corner cases:
- **Sign jump on a zero accumulator.** It runs a default core and a strict core side by side. A core with the comparison swapped takes or skips the jump on the wrong one.
- **Wrapping arithmetic and the signed range.** It adds past 0xFFFF, subtracts below 0x8000, and jumps on 0x8000 and 0x7FFF. An adder that saturated, or a sign test that looked at the wrong bit, stores the wrong value.
- **Program-counter wraparound.** A program runs off address 4095 and only finishes if the next fetch comes from address 0.
- **Unassigned opcodes.** The same program passes through an unassigned opcode, which must not change the accumulator.
- **Operand timing.** A cycle-exact trace checks when the operand address and the single-cycle write strobe appear. A core that sampled read data one cycle early loads the instruction word instead of the data.
- **Stop.** A stop instruction carrying a nonzero operand is followed by a store. A core that decoded the operand, or did not stay halted, writes memory.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_EXEC  = 2'd1,
    ST_OPND  = 2'd2,
    ST_HALT  = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    ALU_PASS = 2'd0,
    ALU_ADD  = 2'd1,
    ALU_SUB  = 2'd2
  } alu_op_e;

  // control word produced from the opcode field
  typedef struct packed {
    logic    reads_mem;
    logic    writes_mem;
    alu_op_e alu;
    logic    jump_always;
    logic    jump_sign;
    logic    jump_nz;
    logic    stop;
  } ctrl_t;

endpackage

// File: rtl/acc_core_decode.sv
module acc_core_decode
  import acc_core_pkg::*;
#(
  parameter int OPC_W = 4
) (
  input  logic [OPC_W-1:0] opcode,
  output ctrl_t            ctrl
);

  always_comb begin
    ctrl = '{reads_mem: 1'b0, writes_mem: 1'b0, alu: ALU_PASS,
             jump_always: 1'b0, jump_sign: 1'b0, jump_nz: 1'b0, stop: 1'b0};
    case (opcode)
      OPC_W'(0): ctrl.reads_mem = 1'b1;
      OPC_W'(1): ctrl.writes_mem = 1'b1;
      OPC_W'(2): begin ctrl.reads_mem = 1'b1; ctrl.alu = ALU_ADD; end
      OPC_W'(3): begin ctrl.reads_mem = 1'b1; ctrl.alu = ALU_SUB; end
      OPC_W'(4): ctrl.jump_always = 1'b1;
      OPC_W'(5): ctrl.jump_sign = 1'b1;
      OPC_W'(6): ctrl.jump_nz = 1'b1;
      OPC_W'(7): ctrl.stop = 1'b1;
      default: ;  // unassigned codes behave as no-ops
    endcase
  end

endmodule

// File: rtl/acc_core_branch.sv
module acc_core_branch #(
  parameter int DATA_W      = 16,
  parameter bit JUMP_STRICT = 1'b0
) (
  input  logic [DATA_W-1:0] acc,
  input  logic              jump_always,
  input  logic              jump_sign,
  input  logic              jump_nz,
  output logic              take
);

  logic nonzero;
  logic sign_ok;

  assign nonzero = |acc;

  generate
    if (JUMP_STRICT) begin : g_strict
      assign sign_ok = !acc[DATA_W-1] && nonzero;
    end else begin : g_nonneg
      assign sign_ok = !acc[DATA_W-1];
    end
  endgenerate

  assign take = jump_always | (jump_sign & sign_ok) | (jump_nz & nonzero);

endmodule

// File: rtl/acc_core_datapath.sv
module acc_core_datapath
  import acc_core_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_we,
  input  alu_op_e           alu_op,
  input  logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] acc
);

  logic [DATA_W-1:0] acc_next;

  always_comb begin
    case (alu_op)
      ALU_ADD: acc_next = acc + opnd;
      ALU_SUB: acc_next = acc - opnd;
      default: acc_next = opnd;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else if (acc_we) acc <= acc_next;
  end

  // R5/R10: accumulator only moves on an operand cycle
  a_r10_acc_hold: assert property (@(posedge clk) disable iff (rst)
    !acc_we |=> $stable(acc));

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 12,
  parameter bit JUMP_STRICT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted
);

  localparam int OPC_W = DATA_W - ADDR_W;

  phase_e            phase, phase_n;
  logic [ADDR_W-1:0] pc, pc_n;
  logic [ADDR_W-1:0] operand;
  logic [DATA_W-1:0] acc;
  ctrl_t             ctrl_now;
  alu_op_e           alu_held;
  logic              acc_we;
  logic              take;

  assign operand = mem_rdata[ADDR_W-1:0];

  acc_core_decode #(.OPC_W(OPC_W)) u_dec (
    .opcode (mem_rdata[DATA_W-1 -: OPC_W]),
    .ctrl   (ctrl_now)
  );

  acc_core_branch #(.DATA_W(DATA_W), .JUMP_STRICT(JUMP_STRICT)) u_br (
    .acc         (acc),
    .jump_always (ctrl_now.jump_always),
    .jump_sign   (ctrl_now.jump_sign),
    .jump_nz     (ctrl_now.jump_nz),
    .take        (take)
  );

  acc_core_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .acc_we (acc_we),
    .alu_op (alu_held),
    .opnd   (mem_rdata),
    .acc    (acc)
  );

  always_comb begin
    phase_n  = phase;
    pc_n     = pc;
    mem_addr = pc;
    mem_we   = 1'b0;
    acc_we   = 1'b0;
    case (phase)
      ST_FETCH: begin
        pc_n    = pc + 1'b1;
        phase_n = ST_EXEC;
      end
      ST_EXEC: begin
        if (ctrl_now.stop) begin
          phase_n = ST_HALT;
        end else if (ctrl_now.reads_mem) begin
          mem_addr = operand;
          phase_n  = ST_OPND;
        end else if (ctrl_now.writes_mem) begin
          mem_addr = operand;
          mem_we   = 1'b1;
          phase_n  = ST_FETCH;
        end else begin
          if (take) pc_n = operand;
          phase_n = ST_FETCH;
        end
      end
      ST_OPND: begin
        acc_we  = 1'b1;
        phase_n = ST_FETCH;
      end
      default: phase_n = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= ST_FETCH;
      pc       <= '0;
      alu_held <= ALU_PASS;
    end else begin
      phase <= phase_n;
      pc    <= pc_n;
      if (phase == ST_EXEC) alu_held <= ctrl_now.alu;
    end
  end

  assign mem_wdata = acc;
  assign halted    = (phase == ST_HALT);

  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);
  a_r9_quiet_halted: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we);
  a_r4_single_write: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);
  a_r11_opnd_then_fetch: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_OPND) |=> (phase == ST_FETCH));
  a_r2_fetch_advances: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_FETCH) |=> (pc == $past(pc) + 1'b1));
  a_r6_jump_lands: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_EXEC && ctrl_now.jump_always) |=> (pc == $past(operand)));
  a_r7_sign_jump: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_EXEC && ctrl_now.jump_sign && !acc[DATA_W-1] &&
     (acc != '0 || JUMP_STRICT == 1'b0)) |=> (pc == $past(operand)));
  a_r7_negative_falls_through: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_EXEC && ctrl_now.jump_sign && acc[DATA_W-1]) |=> $stable(pc));

endmodule

// File: tb/sim_acc_core.sv
module sim_acc_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] a0, a1;
  logic [15:0] wd0, wd1, rd0, rd1;
  logic        we0, we1, h0, h1;
  logic [15:0] mem0 [4096];
  logic [15:0] mem1 [4096];
  logic        ld_en = 1'b0;
  logic [11:0] ld_addr = '0;
  logic [15:0] ld_data = '0;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  acc_core #(.JUMP_STRICT(1'b0)) u0 (
    .clk(clk), .rst(rst), .mem_addr(a0), .mem_wdata(wd0), .mem_we(we0),
    .mem_rdata(rd0), .halted(h0));
  acc_core #(.JUMP_STRICT(1'b1)) u1 (
    .clk(clk), .rst(rst), .mem_addr(a1), .mem_wdata(wd1), .mem_we(we1),
    .mem_rdata(rd1), .halted(h1));

  always @(posedge clk) begin
    if (ld_en) begin
      mem0[ld_addr] <= ld_data;
      mem1[ld_addr] <= ld_data;
    end else begin
      if (we0) mem0[a0] <= wd0;
      if (we1) mem1[a1] <= wd1;
    end
    rd0 <= mem0[a0];
    rd1 <= mem1[a1];
  end

  // vector: {opcode, a, b, expected default, expected strict}
  localparam int NV = 13;
  localparam logic [67:0] VEC [NV] = '{
    {4'h2, 16'h0005, 16'h0003, 16'h0008, 16'h0008},
    {4'h2, 16'hFFFF, 16'h0001, 16'h0000, 16'h0000},
    {4'h3, 16'h0005, 16'h0007, 16'hFFFE, 16'hFFFE},
    {4'h3, 16'h8000, 16'h0001, 16'h7FFF, 16'h7FFF},
    {4'h0, 16'h5555, 16'h1234, 16'h1234, 16'h1234},
    {4'h4, 16'h00AA, 16'h0BBB, 16'h00AA, 16'h00AA},
    {4'h5, 16'h0000, 16'h0BBB, 16'h0000, 16'h0BBB},
    {4'h5, 16'h0001, 16'h0BBB, 16'h0001, 16'h0001},
    {4'h5, 16'h8000, 16'h0BBB, 16'h0BBB, 16'h0BBB},
    {4'h5, 16'h7FFF, 16'h0BBB, 16'h7FFF, 16'h7FFF},
    {4'h6, 16'h0000, 16'h0BBB, 16'h0BBB, 16'h0BBB},
    {4'h6, 16'hFFFF, 16'h0BBB, 16'hFFFF, 16'hFFFF},
    {4'h9, 16'h3C3C, 16'h0BBB, 16'h3C3C, 16'h3C3C}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [11:0] adr, input logic [15:0] dat);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = adr; ld_data = dat;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic release_and_run(output bit done);
    done = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (h0 && h1) begin done = 1'b1; break; end
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit done;
    // R1: outputs while in reset
    repeat (3) @(negedge clk);
    #1;
    check("R1 halted in reset", {15'd0, h0}, 16'd0);
    check("R1 we in reset", {15'd0, we0}, 16'd0);
    check("R1 addr in reset", {4'd0, a0}, 16'd0);

    // vector table: one program per entry, both jump variants side by side
    for (int v = 0; v < NV; v++) begin
      logic [3:0]  op;
      logic [15:0] va, vb, e0, e1;
      {op, va, vb, e0, e1} = VEC[v];
      rst = 1'b1;
      put(12'd100, va);
      put(12'd101, vb);
      put(12'd102, 16'hDEAD);
      put(12'd0, 16'h0064);
      if (op == 4'h4 || op == 4'h5 || op == 4'h6) begin
        put(12'd1, {op, 12'd3});
        put(12'd2, 16'h0065);
        put(12'd3, 16'h1066);
        put(12'd4, 16'h7ABC);
      end else begin
        put(12'd1, {op, 12'd101});
        put(12'd2, 16'h1066);
        put(12'd3, 16'h7ABC);
      end
      release_and_run(done);
      check("R9 halt reached", {15'd0, done}, 16'd1);
      // R3 R4 R5 R6 R7 R8 R10 result of the vector
      check($sformatf("R3/R5/R6/R7/R8/R10 vec%0d default", v), mem0[102], e0);
      check($sformatf("R7 vec%0d strict", v), mem1[102], e1);
    end

    // R11 R4 R9: cycle-exact trace
    rst = 1'b1;
    put(12'd100, 16'h4242);
    put(12'd103, 16'hDEAD);
    put(12'd0, 16'h0064);
    put(12'd1, 16'h1066);
    put(12'd2, 16'h7ABC);
    put(12'd3, 16'h1067);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 first fetch addr", {4'd0, a0}, 16'd0);
    check("R1 first fetch we", {15'd0, we0}, 16'd0);
    @(negedge clk); #1;
    check("R11 operand address", {4'd0, a0}, 16'd100);
    @(negedge clk); #1;
    check("R11 operand cycle no write", {15'd0, we0}, 16'd0);
    @(negedge clk); #1;
    check("R2 next fetch addr", {4'd0, a0}, 16'd1);
    @(negedge clk); #1;
    check("R4 store addr", {4'd0, a0}, 16'd102);
    check("R4 store strobe", {15'd0, we0}, 16'd1);
    check("R4 store data", wd0, 16'h4242);
    @(negedge clk); #1;
    check("R4 strobe one cycle", {15'd0, we0}, 16'd0);
    check("R2 fetch after store", {4'd0, a0}, 16'd2);
    @(negedge clk); #1;
    check("R9 not yet halted", {15'd0, h0}, 16'd0);
    @(negedge clk); #1;
    check("R9 halted", {15'd0, h0}, 16'd1);
    begin
      int wr = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk); #1;
        if (we0 || !h0) wr++;
      end
      check("R9 quiet while halted", wr[15:0], 16'd0);
    end
    check("R9 no store after stop", mem0[103], 16'hDEAD);

    // R1: reset leaves halt
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk); #1;
    check("R1 reset clears halted", {15'd0, h0}, 16'd0);

    // R2 R10: run off address 4095 through an unassigned opcode
    put(12'h020, 16'h0007);
    put(12'h021, 16'hDEAD);
    put(12'd0, 16'h6005);
    put(12'd1, 16'h0020);
    put(12'd2, 16'h4FFF);
    put(12'd5, 16'h1021);
    put(12'd6, 16'h7000);
    put(12'hFFF, 16'hF123);
    release_and_run(done);
    check("R2 wrap run halts", {15'd0, done}, 16'd1);
    check("R2/R10 wrap result", mem0[12'h021], 16'h0007);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule